// File: doc/BRIEF.md
# Staggered SDRAM Refresh Scheduler

This block keeps a multi-bank SDRAM array refreshed. A down-counter in system clock cycles expires once per refresh period. The period is the device retention time divided by its row count: for example, 64 ms over 4096 rows gives about 15.6 µs, which is roughly 515 cycles at 33 MHz. Each expiry starts a refresh sequence. The scheduler asks the command arbiter for the bus. Once the arbiter grants it, the scheduler sends one Auto Refresh command to each enabled chip-select bank, lowest index first, one bank per command. This keeps the supply current of several banks refreshing at once off the board.

After each command the scheduler holds the bus for a programmable recovery time and then moves on to the next enabled bank. Banks that are not enabled are skipped at no cost in cycles. Refresh runs only when the enable input is set and the mode input selects normal operation. If a period expires while a sequence is still waiting or running, one extra sequence is remembered and carried out afterwards.

Top module: `sdram_rfsh_sched`

## Requirements
- R1: While refresh is active (`rfsh_en`=1 and `op_mode`=0), the interval timer expires every `intv_reload`+1 cycles. The first expiry falls `intv_reload` cycles after activation, and the first command of a sequence follows 2 cycles after the expiry, provided the grant is high.
- R2: In each refresh period, every bank whose `bank_en` bit is 1 receives exactly one Auto Refresh command, in ascending bank index order. Banks whose bit is 0 receive none.
- R3: At most one bit of `cs_n` is low in any cycle.
- R4: An Auto Refresh command is encoded as the selected `cs_n` bit low, `ras_n`=0, `cas_n`=0 and `we_n`=1. Outside commands, `ras_n`, `cas_n` and `we_n` are all 1.
- R5: While `rfsh_en`=0, no command is issued and `rfsh_req` stays 0 from the next cycle on.
- R6: While `op_mode` is not 0 (the normal mode code), no command is issued and `rfsh_req` stays 0 from the next cycle on.
- R7: `rfsh_req` rises when a sequence is pending and stays high without any command while `arb_gnt` is 0. The first command is issued in the cycle after `arb_gnt` is sampled high.
- R8: Within a sequence, consecutive commands are exactly `trc_cycles`+2 cycles apart, whatever disabled banks lie between them. `rfsh_req` falls `trc_cycles`+2 cycles after the last command of the sequence.
- R9: Expiries that occur while a sequence is waiting or running are remembered as exactly one further sequence, however many of them occur.
- R10: During and right after reset, `cs_n` is all ones, `ras_n`, `cas_n` and `we_n` are 1, and `rfsh_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_en | input | 1 | Refresh enable |
| op_mode | input | 3 | Operation mode code; 0 selects normal operation |
| bank_en | input | 4 | Per-bank enable mask, captured at grant |
| intv_reload | input | 16 | Interval reload value in clock cycles (period = value + 1) |
| trc_cycles | input | 4 | Recovery time after each command (gap = value + 2) |
| arb_gnt | input | 1 | Bus grant from the command arbiter |
| rfsh_req | output | 1 | Bus request, held high for the whole sequence |
| cs_n | output | 4 | Active-low chip select, one per bank |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable |

## Verification
The bench builds the block with its default parameters: four banks, a 16-bit interval counter and a 4-bit recovery counter. With four banks, every shape of enable mask can be driven: empty, full, sparse and single-bank masks. The reload port is programmed with short intervals of 30 to 100 cycles, so two full periods, and the three expiries that pile up behind a withheld grant, fit in a short run. Recovery values from 0 to 5 exercise both back-to-back spacing and longer holds.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CMD  = 2'd2,
    ST_WAIT = 2'd3
  } rfsh_state_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INTV_W-1:0] reload,
  output logic              tick
);
  logic [INTV_W-1:0] cnt_q, cnt_d;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign tick     = run && cnt_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || cnt_zero) cnt_d = reload;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload != '0) |=> !tick);
endmodule

// File: rtl/rfsh_bank_picker.sv
module rfsh_bank_picker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [NUM_BANKS-1:0] mask,
  input  logic [BANK_W:0]      start,
  output logic                 found,
  output logic [BANK_W-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(start))) begin
        found = 1'b1;
        idx   = BANK_W'(i);
      end
    end
  end
endmodule

// File: rtl/rfsh_cmd_drive.sv
module rfsh_cmd_drive #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 fire,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign cs_n[b] = !(fire && (bank == BANK_W'(b)));
  end
  assign ras_n = !fire;
  assign cas_n = !fire;
  assign we_n  = 1'b1;
endmodule

// File: rtl/sdram_rfsh_sched.sv
module sdram_rfsh_sched #(
  parameter int          NUM_BANKS   = 4,
  parameter int          INTV_W      = 16,
  parameter int          TRC_W       = 4,
  parameter int          MODE_W      = 3,
  parameter int unsigned MODE_NORMAL = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rfsh_en,
  input  logic [MODE_W-1:0]    op_mode,
  input  logic [NUM_BANKS-1:0] bank_en,
  input  logic [INTV_W-1:0]    intv_reload,
  input  logic [TRC_W-1:0]     trc_cycles,
  input  logic                 arb_gnt,
  output logic                 rfsh_req,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n
);
  import rfsh_pkg::*;

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  rfsh_state_t          state_q, state_d;
  logic [BANK_W-1:0]    bank_q, bank_d;
  logic [NUM_BANKS-1:0] mask_q, mask_d;
  logic [TRC_W-1:0]     trc_q, trc_d;
  logic                 pend_q, pend_d;

  logic                 active;
  logic                 tick;
  logic [NUM_BANKS-1:0] pick_mask;
  logic [BANK_W:0]      pick_start;
  logic                 pick_found;
  logic [BANK_W-1:0]    pick_idx;

  assign active = rfsh_en && (op_mode == MODE_W'(MODE_NORMAL));

  rfsh_interval_timer #(.INTV_W(INTV_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .reload (intv_reload),
    .tick   (tick)
  );

  assign pick_mask  = (state_q == ST_REQ) ? bank_en : mask_q;
  assign pick_start = (state_q == ST_REQ) ? '0 : ({1'b0, bank_q} + 1'b1);

  rfsh_bank_picker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) picker_i (
    .mask  (pick_mask),
    .start (pick_start),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_comb begin
    state_d = state_q;
    bank_d  = bank_q;
    mask_d  = mask_q;
    trc_d   = trc_q;
    pend_d  = pend_q;
    if (!active) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (tick || pend_q) begin
            state_d = ST_REQ;
            pend_d  = 1'b0;
          end
        end
        ST_REQ: begin
          if (tick) pend_d = 1'b1;
          if (arb_gnt) begin
            mask_d = bank_en;
            if (pick_found) begin
              state_d = ST_CMD;
              bank_d  = pick_idx;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_CMD: begin
          if (tick) pend_d = 1'b1;
          state_d = ST_WAIT;
          trc_d   = trc_cycles;
        end
        ST_WAIT: begin
          if (tick) pend_d = 1'b1;
          if (trc_q == '0) begin
            if (pick_found) begin
              state_d = ST_CMD;
              bank_d  = pick_idx;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            trc_d = trc_q - 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      mask_q  <= '0;
      trc_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      mask_q  <= mask_d;
      trc_q   <= trc_d;
      pend_q  <= pend_d;
    end
  end

  assign rfsh_req = (state_q != ST_IDLE);

  rfsh_cmd_drive #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) drive_i (
    .fire  (state_q == ST_CMD),
    .bank  (bank_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n)
  );

  // R3
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R4
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> (!ras_n && !cas_n && we_n));

  // R5 R6
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (&cs_n && !rfsh_req));

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ && !arb_gnt && active) |=> (rfsh_req && &cs_n));

  // R8
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && active) |=> (&cs_n && rfsh_req));
endmodule

// File: tb/sdram_rfsh_sched_tb_top.sv
module sdram_rfsh_sched_tb_top;
  localparam int NB = 4;

  typedef struct packed {
    logic [15:0] r;
    logic [3:0]  t;
    logic [3:0]  m;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd60, 4'd2, 4'b1111},
    '{16'd50, 4'd0, 4'b0101},
    '{16'd80, 4'd5, 4'b1000},
    '{16'd40, 4'd1, 4'b0110},
    '{16'd30, 4'd3, 4'b0000},
    '{16'd45, 4'd1, 4'b1011}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rfsh_en;
  logic [2:0]    op_mode;
  logic [NB-1:0] bank_en;
  logic [15:0]   intv_reload;
  logic [3:0]    trc_cycles;
  logic          arb_gnt;
  logic          rfsh_req;
  logic [NB-1:0] cs_n;
  logic          ras_n, cas_n, we_n;

  always #5 clk = ~clk;

  sdram_rfsh_sched dut_i (
    .clk(clk), .rst_n(rst_n), .rfsh_en(rfsh_en), .op_mode(op_mode),
    .bank_en(bank_en), .intv_reload(intv_reload), .trc_cycles(trc_cycles),
    .arb_gnt(arb_gnt), .rfsh_req(rfsh_req), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cmd_cyc [64];
  int cmd_bank [64];
  int ncmd = 0;
  int last_fall = -1;
  bit req_seen = 0;
  bit req_prev = 0;
  bit rec_on = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_rec();
    ncmd = 0;
    last_fall = -1;
    req_seen = 0;
    req_prev = rfsh_req;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin : mon
    int nlow;
    int b;
    if (rec_on) begin
      if (cs_n != '1) begin
        nlow = 0;
        b = 0;
        for (int i = 0; i < NB; i++) if (!cs_n[i]) begin nlow++; b = i; end
        chk(nlow == 1, "R3 low chip selects", nlow, 1);
        chk({ras_n, cas_n, we_n} == 3'b001, "R4 command code", {ras_n, cas_n, we_n}, 1);
        if (ncmd < 64) begin
          cmd_cyc[ncmd] = cyc;
          cmd_bank[ncmd] = b;
        end
        ncmd++;
      end
      if (rfsh_req) req_seen = 1;
      if (req_prev && !rfsh_req) last_fall = cyc;
      req_prev = rfsh_req;
    end
  end

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    int t0, r, t, pop, k, expc, expb, idx, lastc;
    rst_n = 0; rfsh_en = 0; op_mode = 0; bank_en = 4'hF;
    intv_reload = 16'd20; trc_cycles = 4'd1; arb_gnt = 1;
    step(3);
    // R10 reset state
    chk(cs_n == '1, "R10 cs_n in reset", cs_n, 15);
    chk({ras_n, cas_n, we_n} == 3'b111, "R10 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(rfsh_req == 0, "R10 req in reset", rfsh_req, 0);
    rst_n = 1;
    step(2);
    chk(cs_n == '1 && rfsh_req == 0, "R10 after reset", {rfsh_req, cs_n}, 15);

    // table walk: R1 R2 R8 R3 R4
    for (int v = 0; v < 6; v++) begin
      rfsh_en = 0; op_mode = 0; arb_gnt = 1;
      intv_reload = VECS[v].r; trc_cycles = VECS[v].t; bank_en = VECS[v].m;
      r = int'(VECS[v].r); t = int'(VECS[v].t); pop = $countones(VECS[v].m);
      step(3);
      clear_rec(); rec_on = 1;
      rfsh_en = 1; t0 = cyc;
      step(2 * r + 9 + pop * (t + 2));
      rfsh_en = 0;
      step(2);
      rec_on = 0;
      chk(ncmd == 2 * pop, "R2 commands in two periods", ncmd, 2 * pop);
      if (ncmd == 2 * pop) begin
        for (int p = 0; p < 2; p++) begin
          k = 0;
          for (int bb = 0; bb < NB; bb++) begin
            if (VECS[v].m[bb]) begin
              idx = p * pop + k;
              expc = t0 + r + 2 + p * (r + 1) + k * (t + 2);
              expb = bb;
              if (k == 0) chk(cmd_cyc[idx] == expc, "R1 sequence start cycle", cmd_cyc[idx] - t0, expc - t0);
              else        chk(cmd_cyc[idx] == expc, "R8 command spacing", cmd_cyc[idx] - t0, expc - t0);
              chk(cmd_bank[idx] == expb, "R2 bank order", cmd_bank[idx], expb);
              k++;
            end
          end
        end
      end
      if (pop > 0) lastc = t0 + r + 2 + (r + 1) + (pop - 1) * (t + 2) + t + 2;
      else         lastc = t0 + 2 * r + 3;
      chk(last_fall == lastc, "R8 request release", last_fall - t0, lastc - t0);
    end

    // R5 refresh disabled
    rfsh_en = 0; op_mode = 0; intv_reload = 16'd20; trc_cycles = 4'd1; bank_en = 4'hF; arb_gnt = 1;
    step(2); clear_rec(); rec_on = 1;
    step(80); rec_on = 0;
    chk(ncmd == 0, "R5 commands while disabled", ncmd, 0);
    chk(req_seen == 0, "R5 request while disabled", req_seen, 0);

    // R6 non-normal modes
    for (int mm = 1; mm < 8; mm += 3) begin
      op_mode = 3'(mm); rfsh_en = 1;
      step(2); clear_rec(); rec_on = 1;
      step(80); rec_on = 0;
      chk(ncmd == 0, "R6 commands in other mode", ncmd, 0);
      chk(req_seen == 0, "R6 request in other mode", req_seen, 0);
    end
    rfsh_en = 0; op_mode = 0;
    step(2);

    // R7 R9 grant withheld over three expiries
    intv_reload = 16'd100; trc_cycles = 4'd2; bank_en = 4'hF; arb_gnt = 0;
    step(2); clear_rec(); rec_on = 1;
    rfsh_en = 1; t0 = cyc;
    step(3 * 100 + 9);
    chk(ncmd == 0, "R7 no command without grant", ncmd, 0);
    chk(rfsh_req == 1, "R7 request held", rfsh_req, 1);
    arb_gnt = 1;
    expc = cyc + 1;
    step(100 - 12);
    rec_on = 0;
    chk(ncmd > 0 && cmd_cyc[0] == expc, "R7 first command after grant", ncmd > 0 ? cmd_cyc[0] - t0 : -1, expc - t0);
    chk(ncmd == 8, "R9 one pending sequence kept", ncmd, 8);
    rfsh_en = 0;
    step(3);
    report();
  end
endmodule